// File: doc/BRIEF.md
# Extended Divide and Signed Multiply Unit

This unit is the multi-cycle arithmetic helper of a 16-bit core. It takes the accumulator `D` and the index registers `X` and `Y` as operands and performs one of four operations: a 16-by-16 signed divide, a 32-by-16 unsigned divide, a 32-by-16 signed divide, or a 16-by-16 signed multiply. Its results go back to those same registers, and it also sets the carry (C), zero (Z), negative (N) and overflow (V) flags. For each destination it raises a write enable in the cycle the result is ready. The register file and flag storage stay outside the unit.

The core raises `start` for one cycle with `op` and the three operands. While `busy` is high, further `start` pulses are ignored. The divides run a shift-and-subtract loop with one iteration per bit of the 32-bit magnitude dividend, and the signs are applied when the loop finishes. The multiply uses a single registered product. `done` is high for exactly one cycle, and in that cycle the write enables say which registers and flags take the values on the result outputs.

Top module: `xdivmul_unit`

## Requirements
- R1: With `op`=0, the signed dividend D is divided by the signed divisor X. The quotient goes to X and the remainder to D. C=0. Z is set when the quotient is zero. N is quotient bit 15. C, Z, N and V are all written.
- R2: With `op`=1, the unsigned 32-bit dividend {Y,D} (Y as the upper half) is divided by the unsigned X. The low 16 bits of the quotient go to Y and the remainder to D. C=0. Z is set when the full quotient is zero. N is quotient bit 15.
- R3: With `op`=2, the signed 32-bit dividend {Y,D} is divided by the signed X. The low 16 bits of the quotient go to Y and the remainder to D. C=0. Z is set when the quotient is zero. N is quotient bit 15.
- R4: With `op`=3, the 32-bit product of signed D and signed Y is formed. Bits 15:0 go to D and bits 31:16 to Y. Z is set when the product is zero, N is product bit 31 and C is product bit 15. V is not written.
- R5: A divide with X=0 writes C=1 and nothing else: no register write enable and no write enable for Z, N or V.
- R6: For the signed divides, V=1 when the true quotient lies outside -32768..32767. For the unsigned divide, V=1 when the quotient needs more than 16 bits.
- R7: Signed divides truncate toward zero. The remainder takes the sign of the dividend.
- R8: If `start` is accepted at rising edge E, a multiply or a divide by zero has `done` high after edge E+1, and any other divide has `done` high after edge E+33.
- R9: `done` lasts exactly one cycle. Write enables are high only while `done` is high. The result outputs hold their values when `done` is low.
- R10: `busy` is high from the edge that accepts a `start` until the edge that raises `done`. A `start` seen while `busy` is high is ignored.
- R11: A `start` raised in the cycle where `done` is high is accepted, so operations can issue back to back.
- R12: After reset, `done`, `busy`, every write enable and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an operation |
| op | input | 2 | 0 signed 16/16 div, 1 unsigned 32/16 div, 2 signed 32/16 div, 3 signed multiply |
| d_in | input | W | Operand D |
| x_in | input | W | Operand X |
| y_in | input | W | Operand Y |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| d_out | output | W | Result for D |
| x_out | output | W | Result for X |
| y_out | output | W | Result for Y |
| d_we | output | 1 | Write D |
| x_we | output | 1 | Write X |
| y_we | output | 1 | Write Y |
| c_out | output | 1 | Carry flag value |
| z_out | output | 1 | Zero flag value |
| n_out | output | 1 | Negative flag value |
| v_out | output | 1 | Overflow flag value |
| c_we | output | 1 | Write C |
| z_we | output | 1 | Write Z |
| n_we | output | 1 | Write N |
| v_we | output | 1 | Write V |

## Verification
The two events that can share a cycle are the completion of one operation and the acceptance of the next. The unit goes idle on the same edge that raises `done`, so a `start` held high is taken in the `done` cycle. To provoke this, `start` is held high for hundreds of cycles while the operation and operands are randomised every cycle. A behavioural model counts down its own latency, accepts a request only when idle, and is compared with `done`, `busy`, every write enable and the written values on each clock. A separate directed phase pulses `start` in the middle of a divide to show that such a request is dropped.

// File: rtl/xdm_pkg.sv
package xdm_pkg;
  typedef enum logic [1:0] {
    OP_SDIV16 = 2'd0,
    OP_UDIV32 = 2'd1,
    OP_SDIV32 = 2'd2,
    OP_SMUL   = 2'd3
  } xdm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_MUL  = 2'd2,
    ST_ZERO = 2'd3
  } xdm_state_e;
endpackage

// File: rtl/xdm_opprep.sv
// Turns raw operands into magnitudes plus sign bits for the unsigned divider core.
module xdm_opprep #(
  parameter int W = 16
) (
  input  logic [1:0]     op,
  input  logic [W-1:0]   d_in,
  input  logic [W-1:0]   x_in,
  input  logic [W-1:0]   y_in,
  output logic [2*W-1:0] num_mag,
  output logic [W-1:0]   den_mag,
  output logic           neg_num,
  output logic           neg_den,
  output logic           den_zero
);
  import xdm_pkg::*;
  localparam int NW = 2 * W;

  logic [NW-1:0] num_raw;

  always_comb begin
    num_raw = {y_in, d_in};
    neg_num = 1'b0;
    neg_den = 1'b0;
    case (xdm_op_e'(op))
      OP_SDIV16: begin
        num_raw = {{W{d_in[W-1]}}, d_in};
        neg_num = d_in[W-1];
        neg_den = x_in[W-1];
      end
      OP_SDIV32: begin
        neg_num = y_in[W-1];
        neg_den = x_in[W-1];
      end
      default: ;
    endcase
    num_mag  = neg_num ? (~num_raw + 1'b1) : num_raw;
    den_mag  = neg_den ? (~x_in + 1'b1) : x_in;
    den_zero = (x_in == '0);
  end
endmodule

// File: rtl/xdm_divider.sv
// Restoring shift-subtract divider, one quotient bit per clock.
module xdm_divider #(
  parameter int NW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          fin,
  output logic [NW-1:0] quo,
  output logic [DW-1:0] rem
);
  localparam int CW = $clog2(NW + 1);

  logic [CW-1:0] cnt;
  logic [DW-1:0] den_q;
  logic [DW:0]   trial;
  logic [DW:0]   diff;

  assign trial = {rem, quo[NW-1]};
  assign diff  = trial - {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      fin   <= 1'b0;
      quo   <= '0;
      rem   <= '0;
      den_q <= '0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        cnt   <= CW'(NW);
        quo   <= num;
        rem   <= '0;
        den_q <= den;
      end else if (cnt != '0) begin
        if (!diff[DW]) begin
          rem <= diff[DW-1:0];
          quo <= {quo[NW-2:0], 1'b1};
        end else begin
          rem <= trial[DW-1:0];
          quo <= {quo[NW-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) fin <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/xdm_mulcore.sv
// Registered signed multiplier, shaped for a DSP slice.
module xdm_mulcore #(
  parameter int W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [2*W-1:0]   prod
);
  always_ff @(posedge clk) begin
    if (rst) prod <= '0;
    else if (load) prod <= $signed(a) * $signed(b);
  end
endmodule

// File: rtl/xdivmul_unit.sv
module xdivmul_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] d_in,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] d_out,
  output logic [W-1:0] x_out,
  output logic [W-1:0] y_out,
  output logic         d_we,
  output logic         x_we,
  output logic         y_we,
  output logic         c_out,
  output logic         z_out,
  output logic         n_out,
  output logic         v_out,
  output logic         c_we,
  output logic         z_we,
  output logic         n_we,
  output logic         v_we
);
  import xdm_pkg::*;
  localparam int NW = 2 * W;

  xdm_state_e    state;
  xdm_op_e       op_q;
  logic          neg_num_q, neg_den_q;

  logic [NW-1:0] num_mag;
  logic [W-1:0]  den_mag;
  logic          neg_num, neg_den, den_zero;
  logic          accept, div_load, mul_load;
  logic          div_fin;
  logic [NW-1:0] div_quo;
  logic [W-1:0]  div_rem;
  logic [NW-1:0] prod;

  logic          signed_op, q_neg, q_ovf;
  logic [NW:0]   q_ext, q_sgn;
  logic [W-1:0]  r_sgn;

  assign busy     = (state != ST_IDLE);
  assign accept   = start && (state == ST_IDLE);
  assign div_load = accept && (xdm_op_e'(op) != OP_SMUL) && !den_zero;
  assign mul_load = accept && (xdm_op_e'(op) == OP_SMUL);

  xdm_opprep #(.W(W)) u_prep (
    .op(op), .d_in(d_in), .x_in(x_in), .y_in(y_in),
    .num_mag(num_mag), .den_mag(den_mag),
    .neg_num(neg_num), .neg_den(neg_den), .den_zero(den_zero)
  );

  xdm_divider #(.NW(NW), .DW(W)) u_div (
    .clk(clk), .rst(rst), .load(div_load), .num(num_mag), .den(den_mag),
    .fin(div_fin), .quo(div_quo), .rem(div_rem)
  );

  xdm_mulcore #(.W(W)) u_mul (
    .clk(clk), .rst(rst), .load(mul_load), .a(d_in), .b(y_in), .prod(prod)
  );

  // Sign fix-up of the magnitude results.
  always_comb begin
    signed_op = (op_q != OP_UDIV32);
    q_neg     = signed_op && (neg_num_q ^ neg_den_q);
    q_ext     = {1'b0, div_quo};
    q_sgn     = q_neg ? (~q_ext + 1'b1) : q_ext;
    r_sgn     = neg_num_q ? (~div_rem + 1'b1) : div_rem;
    if (signed_op)
      q_ovf = !((&q_sgn[NW:W-1]) || !(|q_sgn[NW:W-1]));
    else
      q_ovf = |div_quo[NW-1:W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= OP_SDIV16;
      neg_num_q <= 1'b0;
      neg_den_q <= 1'b0;
      done      <= 1'b0;
      d_out <= '0; x_out <= '0; y_out <= '0;
      d_we  <= 1'b0; x_we <= 1'b0; y_we <= 1'b0;
      c_out <= 1'b0; z_out <= 1'b0; n_out <= 1'b0; v_out <= 1'b0;
      c_we  <= 1'b0; z_we <= 1'b0; n_we <= 1'b0; v_we <= 1'b0;
    end else begin
      done <= 1'b0;
      d_we <= 1'b0; x_we <= 1'b0; y_we <= 1'b0;
      c_we <= 1'b0; z_we <= 1'b0; n_we <= 1'b0; v_we <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            op_q      <= xdm_op_e'(op);
            neg_num_q <= neg_num;
            neg_den_q <= neg_den;
            if (xdm_op_e'(op) == OP_SMUL) state <= ST_MUL;
            else if (den_zero)            state <= ST_ZERO;
            else                          state <= ST_DIV;
          end
        end
        ST_DIV: begin
          if (div_fin) begin
            state <= ST_IDLE;
            done  <= 1'b1;
            d_out <= r_sgn;
            d_we  <= 1'b1;
            if (op_q == OP_SDIV16) begin
              x_out <= q_sgn[W-1:0];
              x_we  <= 1'b1;
            end else begin
              y_out <= q_sgn[W-1:0];
              y_we  <= 1'b1;
            end
            c_out <= 1'b0;
            z_out <= (q_sgn == '0);
            n_out <= q_sgn[W-1];
            v_out <= q_ovf;
            c_we <= 1'b1; z_we <= 1'b1; n_we <= 1'b1; v_we <= 1'b1;
          end
        end
        ST_MUL: begin
          state <= ST_IDLE;
          done  <= 1'b1;
          d_out <= prod[W-1:0];
          y_out <= prod[NW-1:W];
          d_we  <= 1'b1;
          y_we  <= 1'b1;
          c_out <= prod[W-1];
          z_out <= (prod == '0);
          n_out <= prod[NW-1];
          c_we <= 1'b1; z_we <= 1'b1; n_we <= 1'b1;
        end
        default: begin
          state <= ST_IDLE;
          done  <= 1'b1;
          c_out <= 1'b1;
          c_we  <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/xdivmul_unit_chk.sv
module xdivmul_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [1:0]   op,
  input logic [W-1:0] x_in,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] d_out,
  input logic         d_we,
  input logic         x_we,
  input logic         y_we,
  input logic         c_out,
  input logic         c_we,
  input logic         z_we,
  input logic         n_we,
  input logic         v_we
);
  logic [1:0] op_seen;

  always_ff @(posedge clk) begin
    if (rst) op_seen <= 2'd0;
    else if (start && !busy) op_seen <= op;
  end

  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_we_with_done: assert property (@(posedge clk) disable iff (rst)
    (d_we || x_we || y_we || c_we || z_we || n_we || v_we) |-> done);

  a_r9_hold_d: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(d_out));

  a_r10_busy_after_start: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r8_mul_latency: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op == 2'd3) |-> ##2 done);

  a_r5_zero_latency: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && op != 2'd3 && x_in == '0) |-> ##2 (done && c_we && c_out));

  a_r5_zero_no_writes: assert property (@(posedge clk) disable iff (rst)
    (done && op_seen != 2'd3 && c_out) |-> !(d_we || x_we || y_we || z_we || n_we || v_we));

  a_r4_mul_no_v: assert property (@(posedge clk) disable iff (rst)
    (done && op_seen == 2'd3) |-> !v_we);
endmodule

bind xdivmul_unit xdivmul_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .op(op), .x_in(x_in),
  .busy(busy), .done(done), .d_out(d_out),
  .d_we(d_we), .x_we(x_we), .y_we(y_we),
  .c_out(c_out), .c_we(c_we), .z_we(z_we), .n_we(n_we), .v_we(v_we)
);

// File: tb/xdivmul_unit_test.sv
`timescale 1ns/1ps
module xdivmul_unit_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [W-1:0] d_in = '0, x_in = '0, y_in = '0;
  logic busy, done, d_we, x_we, y_we, c_out, z_out, n_out, v_out;
  logic c_we, z_we, n_we, v_we;
  logic [W-1:0] d_out, x_out, y_out;

  always #5 clk = ~clk;

  xdivmul_unit #(.W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .op(op),
    .d_in(d_in), .x_in(x_in), .y_in(y_in),
    .busy(busy), .done(done),
    .d_out(d_out), .x_out(x_out), .y_out(y_out),
    .d_we(d_we), .x_we(x_we), .y_we(y_we),
    .c_out(c_out), .z_out(z_out), .n_out(n_out), .v_out(v_out),
    .c_we(c_we), .z_we(z_we), .n_we(n_we), .v_we(v_we)
  );

  int compared = 0;
  int mismatched = 0;
  string cur_tag = "R12";

  // Reference model state
  int   m_cnt = 0;
  bit   m_done = 1'b0;
  bit [6:0] e_we;         // {d,x,y,c,z,n,v}
  bit [15:0] e_d, e_x, e_y;
  bit   e_c, e_z, e_n, e_v;
  string e_tag = "R1";

  task automatic model_eval(input bit [1:0] o, input bit [15:0] d, input bit [15:0] x,
                            input bit [15:0] y, output int lat);
    longint n, dv, q, r, p;
    e_we = '0; e_c = 0; e_z = 0; e_n = 0; e_v = 0;
    lat = 33;
    if (o == 2'd3) begin
      e_tag = "R4";
      n = $signed(d); dv = $signed(y);
      p = n * dv;
      e_d = p[15:0]; e_y = p[31:16];
      e_c = p[15]; e_z = (p[31:0] == 32'd0); e_n = p[31];
      e_we = 7'b1011110;
      lat = 1;
    end else if (x == 16'd0) begin
      e_tag = "R5";
      e_c = 1'b1;
      e_we = 7'b0001000;
      lat = 1;
    end else begin
      if (o == 2'd0) begin
        e_tag = "R1";
        n = $signed(d); dv = $signed(x);
      end else if (o == 2'd1) begin
        e_tag = "R2";
        n = {32'd0, y, d}; dv = {48'd0, x};
      end else begin
        e_tag = "R3";
        n = $signed({y, d}); dv = $signed(x);
      end
      q = n / dv; r = n % dv;
      e_d = r[15:0];
      if (o == 2'd0) begin e_x = q[15:0]; e_we = 7'b1101111; end
      else begin e_y = q[15:0]; e_we = 7'b1011111; end
      e_z = (q == 0); e_n = q[15];
      e_v = (o == 2'd1) ? (q > 65535) : (q > 32767 || q < -32768);
    end
  endtask

  always @(posedge clk) begin
    int lat;
    if (rst) begin
      m_cnt = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) m_done = 1;
      end else if (start) begin
        model_eval(op, d_in, x_in, y_in, lat);
        m_cnt = lat;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s/%s %s: actual %0h expected %0h at %0t", cur_tag, e_tag, what, act, exp, $time);
    end
  endtask

  bit in_reset_check = 1'b0;
  always @(negedge clk) begin
    if (!rst && !in_reset_check) begin
      chk(done == m_done, "R8 done", done, m_done);
      chk(busy == (m_cnt != 0), "R10 busy", busy, m_cnt != 0);
      if (m_done) begin
        chk({d_we,x_we,y_we,c_we,z_we,n_we,v_we} == e_we, "R9 write enables",
            {d_we,x_we,y_we,c_we,z_we,n_we,v_we}, e_we);
        if (e_we[6]) chk(d_out == e_d, "R7 D result", d_out, e_d);
        if (e_we[5]) chk(x_out == e_x, "X result", x_out, e_x);
        if (e_we[4]) chk(y_out == e_y, "Y result", y_out, e_y);
        if (e_we[3]) chk(c_out == e_c, "C flag", c_out, e_c);
        if (e_we[2]) chk(z_out == e_z, "Z flag", z_out, e_z);
        if (e_we[1]) chk(n_out == e_n, "N flag", n_out, e_n);
        if (e_we[0]) chk(v_out == e_v, "R6 V flag", v_out, e_v);
      end else begin
        chk({d_we,x_we,y_we,c_we,z_we,n_we,v_we} == 7'd0, "R9 stray write enable",
            {d_we,x_we,y_we,c_we,z_we,n_we,v_we}, 0);
      end
    end
  end

  task automatic run_op(input bit [1:0] o, input bit [15:0] d, input bit [15:0] x, input bit [15:0] y);
    @(negedge clk);
    start = 1'b1; op = o; d_in = d; x_in = x; y_in = y;
    @(negedge clk);
    start = 1'b0;
    while (busy || m_cnt != 0) @(negedge clk);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    in_reset_check = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk({done,busy,d_we,x_we,y_we,c_we,z_we,n_we,v_we} == 9'd0, "R12 control after reset",
        {done,busy,d_we,x_we,y_we,c_we,z_we,n_we,v_we}, 0);
    chk({d_out,x_out,y_out,c_out,z_out,n_out,v_out} == '0, "R12 data after reset",
        {d_out,x_out,y_out}, 0);
    in_reset_check = 1'b0;

    cur_tag = "R1";  run_op(2'd0, 16'd100, 16'd7, 16'h1234);
    cur_tag = "R7";  run_op(2'd0, 16'hFF9C, 16'd7, 16'd0);      // -100/7
    cur_tag = "R7";  run_op(2'd2, 16'hFFF0, 16'hFFFD, 16'hFFFF); // -16/-3
    cur_tag = "R6";  run_op(2'd0, 16'h8000, 16'hFFFF, 16'd0);    // -32768/-1
    cur_tag = "R2";  run_op(2'd1, 16'h5678, 16'd3, 16'h0001);
    cur_tag = "R6";  run_op(2'd1, 16'h0000, 16'd1, 16'h0002);    // quotient too wide
    cur_tag = "R3";  run_op(2'd2, 16'h0000, 16'hFFFF, 16'h8000); // min/-1
    cur_tag = "R3";  run_op(2'd2, 16'h0000, 16'd2, 16'h0001);
    cur_tag = "R4";  run_op(2'd3, 16'h8000, 16'd0, 16'h8000);
    cur_tag = "R4";  run_op(2'd3, 16'd0, 16'd0, 16'h7FFF);
    cur_tag = "R4";  run_op(2'd3, 16'hFFFF, 16'd0, 16'd1);
    cur_tag = "R5";  run_op(2'd0, 16'd5, 16'd0, 16'd9);
    cur_tag = "R5";  run_op(2'd1, 16'd5, 16'd0, 16'd9);
    cur_tag = "R5";  run_op(2'd2, 16'd5, 16'd0, 16'd9);

    // R10: start during a divide is dropped
    cur_tag = "R10";
    @(negedge clk);
    start = 1'b1; op = 2'd1; d_in = 16'hAAAA; x_in = 16'd77; y_in = 16'd12;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; op = 2'd3; d_in = 16'd3; y_in = 16'd4;
    @(negedge clk); start = 1'b0;
    while (busy || m_cnt != 0) @(negedge clk);

    // R8: mixed random traffic
    cur_tag = "R8";
    for (int i = 0; i < 150; i++) begin
      bit [15:0] xr;
      xr = $urandom;
      if (i % 17 == 0) xr = 16'd0;
      run_op(2'($urandom), 16'($urandom), xr, 16'($urandom));
    end

    // R11: start held high, operands change every cycle
    cur_tag = "R11";
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      start = 1'b1;
      op = 2'($urandom);
      d_in = 16'($urandom);
      x_in = (i % 13 == 0) ? 16'd0 : 16'($urandom);
      y_in = 16'($urandom);
    end
    @(negedge clk); start = 1'b0;
    while (busy || m_cnt != 0) @(negedge clk);
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule